// File: doc/BRIEF.md
# Word-to-Byte Bus Width Adapter

This block joins a 16-bit processor memory window to a set of expansion-card slots. Each slot is either 8 bits or 16 bits wide, and that width is fixed by a parameter. A word request for an 8-bit card becomes two byte accesses on a narrow card port: the odd byte address goes first and the even byte address second. The two bytes are then rebuilt into one big-endian word. A request for a 16-bit card is passed through as one access on a wide card port.

The processor side has no byte enables. A partial write is formed by merging the new data with the last word the window returned, under a keep mask. The full merged word is then written to the card. The last-read word is updated by every completed read, including reads that arrive while no card is selected. Each access has a fixed cost in cycles that depends on the width of the selected card, and a one-cycle ready pulse marks its completion. The selection of a card (valid flag and slot number) is made outside this block.

Top module: `wbw_adapter`

## Requirements
- R1: For an 8-bit slot, a request to word offset N strobes the narrow port at byte address 2N+1 in the first cycle after acceptance and at byte address 2N in the next cycle. No other narrow strobes occur for that request.
- R2: Read data from an 8-bit slot has the even-address byte in bits 15:8 and the odd-address byte in bits 7:0. It appears on `cpu_rdata` while `cpu_ready` is high.
- R3: Every completed read loads its result into the last-read word. This includes a read with no card selected, which loads zero.
- R4: Write data is formed as (last-read AND `cpu_keep`) OR (`cpu_wdata` AND NOT `cpu_keep`). A keep bit of 1 preserves the last-read bit, and the whole merged word is written.
- R5: For an 8-bit slot, the merged word's bits 7:0 are written to address 2N+1 first, and its bits 15:8 are written to address 2N second.
- R6: A slot whose bit in `SLOT_WIDE` is 1 gets exactly one wide-port strobe. That strobe carries the word offset N and, for writes, the full merged word. The narrow port stays idle.
- R7: `cpu_ready` is a one-cycle pulse. It rises W clock edges after the accepting edge, where W = `WAIT8` (default 4) for an 8-bit slot, `WAIT16` (default 1) for a 16-bit slot, and `WAIT_NONE` (default 4) with no card selected.
- R8: With `sel_valid` low, neither card port is strobed, and a read returns zero.
- R9: `cpu_req` is ignored while an access is in progress. Such a request produces no card access and no ready pulse.
- R10: After reset, `cpu_ready`, both strobes and the last-read word are zero.
- R11: A write completion leaves `cpu_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request, sampled while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word offset in the window |
| cpu_wdata | input | 16 | Write data |
| cpu_keep | input | 16 | Per-bit keep mask for writes (1 = take last-read bit) |
| sel_valid | input | 1 | A card is selected |
| sel_slot | input | SLOT_W | Selected slot number |
| cpu_ready | output | 1 | Completion pulse |
| cpu_rdata | output | 16 | Read data, valid with ready |
| nar_stb | output | 1 | Narrow port strobe |
| nar_we | output | 1 | Narrow port write |
| nar_addr | output | ADDR_W+1 | Narrow port byte address |
| nar_wdata | output | 8 | Narrow port write byte |
| nar_rdata | input | 8 | Narrow port read byte, valid while strobed |
| wide_stb | output | 1 | Wide port strobe |
| wide_we | output | 1 | Wide port write |
| wide_addr | output | ADDR_W | Wide port word offset |
| wide_wdata | output | 16 | Wide port write word |
| wide_rdata | input | 16 | Wide port read word, valid while strobed |

## Verification
The bench builds the adapter with a 6-bit word offset, four slots and `SLOT_WIDE` = 4'b1010, so that slots 0 and 2 are narrow and slots 1 and 3 are wide. The wait counts stay at their defaults of 4, 1 and 4. This setup puts narrow and wide slots side by side. It makes a narrow access several cycles longer than a wide one, which leaves room for a second request to arrive while a byte sequence is still in progress. It also makes back-to-back wide accesses possible on consecutive ready pulses. Because the card models are small, every byte and word touched can be read back through the window.

// File: rtl/wbw_pkg.sv
package wbw_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_NONE,
    PH_ODD,
    PH_EVEN,
    PH_WORD
  } phase_e;
endpackage

// File: rtl/wbw_lastread.sv
module wbw_lastread
  import wbw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [WORD_W-1:0] cap_word,
  input  logic [WORD_W-1:0] keep,
  input  logic [WORD_W-1:0] new_data,
  output logic [WORD_W-1:0] merged
);
  logic [WORD_W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)          held_q <= '0;
    else if (capture) held_q <= cap_word;
  end

  // keep bit 1 selects the stored bit, 0 the fresh bit
  assign merged = (held_q & keep) | (new_data & ~keep);
endmodule

// File: rtl/wbw_wait_cnt.sv
module wbw_wait_cnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (load)               cnt_q <= load_val;
    else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/wbw_adapter.sv
module wbw_adapter
  import wbw_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_SLOTS = 16,
  parameter logic [NUM_SLOTS-1:0] SLOT_WIDE = '0,
  parameter int WAIT8     = 4,   // must be at least 2 (two byte phases)
  parameter int WAIT16    = 1,
  parameter int WAIT_NONE = 4,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [15:0]       cpu_wdata,
  input  logic [15:0]       cpu_keep,
  input  logic              sel_valid,
  input  logic [SLOT_W-1:0] sel_slot,
  output logic              cpu_ready,
  output logic [15:0]       cpu_rdata,
  output logic              nar_stb,
  output logic              nar_we,
  output logic [ADDR_W:0]   nar_addr,
  output logic [7:0]        nar_wdata,
  input  logic [7:0]        nar_rdata,
  output logic              wide_stb,
  output logic              wide_we,
  output logic [ADDR_W-1:0] wide_addr,
  output logic [15:0]       wide_wdata,
  input  logic [15:0]       wide_rdata
);
  localparam int MAP_N  = 1 << SLOT_W;
  localparam logic [MAP_N-1:0] WIDE_MAP = MAP_N'(SLOT_WIDE);
  localparam int WMAX_A = (WAIT8 > WAIT16) ? WAIT8 : WAIT16;
  localparam int WMAX   = (WMAX_A > WAIT_NONE) ? WMAX_A : WAIT_NONE;
  localparam int CNT_W  = (WMAX > 1) ? $clog2(WMAX) : 1;

  logic              busy_q;
  phase_e            phase_q;
  logic              rd_q, wide_q, blank_q;
  logic [BYTE_W-1:0] lo_q, hi_q, wr_hi_q;
  logic [WORD_W-1:0] wq_q;

  logic              accept, finish, cnt_zero, slot_wide;
  logic [CNT_W-1:0]  wait_load;
  logic [WORD_W-1:0] merged, rd_word;
  logic [BYTE_W-1:0] hi_src, lo_src;
  logic [WORD_W-1:0] wd_src;

  assign accept    = cpu_req && !busy_q;
  assign finish    = busy_q && cnt_zero;
  assign slot_wide = WIDE_MAP[sel_slot];

  always_comb begin
    if (!sel_valid)     wait_load = CNT_W'(WAIT_NONE - 1);
    else if (slot_wide) wait_load = CNT_W'(WAIT16 - 1);
    else                wait_load = CNT_W'(WAIT8 - 1);
  end

  // bypass: a phase may end on the same edge as the access
  always_comb begin
    hi_src = (phase_q == PH_EVEN) ? nar_rdata  : hi_q;
    lo_src = (phase_q == PH_ODD)  ? nar_rdata  : lo_q;
    wd_src = (phase_q == PH_WORD) ? wide_rdata : wq_q;
    if (blank_q)     rd_word = '0;
    else if (wide_q) rd_word = wd_src;
    else             rd_word = {hi_src, lo_src};
  end

  wbw_lastread u_lastread (
    .clk      (clk),
    .rst      (rst),
    .capture  (finish && rd_q),
    .cap_word (rd_word),
    .keep     (cpu_keep),
    .new_data (cpu_wdata),
    .merged   (merged)
  );

  wbw_wait_cnt #(.CNT_W(CNT_W)) u_wait (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (wait_load),
    .run      (busy_q),
    .zero     (cnt_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      phase_q    <= PH_NONE;
      rd_q       <= 1'b0;
      wide_q     <= 1'b0;
      blank_q    <= 1'b0;
      lo_q       <= '0;
      hi_q       <= '0;
      wr_hi_q    <= '0;
      wq_q       <= '0;
      cpu_ready  <= 1'b0;
      cpu_rdata  <= '0;
      nar_stb    <= 1'b0;
      nar_we     <= 1'b0;
      nar_addr   <= '0;
      nar_wdata  <= '0;
      wide_stb   <= 1'b0;
      wide_we    <= 1'b0;
      wide_addr  <= '0;
      wide_wdata <= '0;
    end else begin
      cpu_ready <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        rd_q    <= !cpu_we;
        wide_q  <= sel_valid && slot_wide;
        blank_q <= !sel_valid;
        wr_hi_q <= merged[15:8];
        if (sel_valid && !slot_wide) begin
          nar_stb   <= 1'b1;
          nar_we    <= cpu_we;
          nar_addr  <= {cpu_addr, 1'b1};
          nar_wdata <= merged[7:0];
          phase_q   <= PH_ODD;
        end else if (sel_valid) begin
          wide_stb   <= 1'b1;
          wide_we    <= cpu_we;
          wide_addr  <= cpu_addr;
          wide_wdata <= merged;
          phase_q    <= PH_WORD;
        end else begin
          phase_q <= PH_NONE;
        end
      end else if (busy_q) begin
        unique case (phase_q)
          PH_ODD: begin
            lo_q      <= nar_rdata;
            nar_addr  <= {nar_addr[ADDR_W:1], 1'b0};
            nar_wdata <= wr_hi_q;
            phase_q   <= PH_EVEN;
          end
          PH_EVEN: begin
            hi_q    <= nar_rdata;
            nar_stb <= 1'b0;
            nar_we  <= 1'b0;
            phase_q <= PH_NONE;
          end
          PH_WORD: begin
            wq_q     <= wide_rdata;
            wide_stb <= 1'b0;
            wide_we  <= 1'b0;
            phase_q  <= PH_NONE;
          end
          default: ;
        endcase
        if (cnt_zero) begin
          busy_q    <= 1'b0;
          cpu_ready <= 1'b1;
          if (rd_q) cpu_rdata <= rd_word;
        end
      end
    end
  end
endmodule

// File: rtl/wbw_adapter_chk.sv
module wbw_adapter_chk #(
  parameter int ADDR_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            cpu_ready,
  input logic            nar_stb,
  input logic [ADDR_W:0] nar_addr,
  input logic            wide_stb
);
  // R1: the odd byte is followed at once by its even partner
  p_odd_then_even_r1: assert property (@(posedge clk) disable iff (rst)
    (nar_stb && nar_addr[0]) |=>
      (nar_stb && !nar_addr[0] && nar_addr[ADDR_W:1] == $past(nar_addr[ADDR_W:1])));

  // R5: an even byte access only ever follows an odd one
  p_even_after_odd_r5: assert property (@(posedge clk) disable iff (rst)
    (nar_stb && !nar_addr[0]) |-> ($past(nar_stb) && $past(nar_addr[0])));

  // R6: a wide access is a single strobe cycle
  p_wide_single_r6: assert property (@(posedge clk) disable iff (rst)
    wide_stb |=> !wide_stb);

  // R8: the two card ports are never strobed together
  p_ports_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(nar_stb && wide_stb));

  // R7: ready is a single-cycle pulse
  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);
endmodule

bind wbw_adapter wbw_adapter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_ready (cpu_ready),
  .nar_stb   (nar_stb),
  .nar_addr  (nar_addr),
  .wide_stb  (wide_stb)
);

// File: tb/wbw_adapter_tb_top.sv
module wbw_adapter_tb_top;
  localparam int AW = 6;
  localparam int NS = 4;
  localparam logic [NS-1:0] SLOT_MAP = 4'b1010;
  localparam int W8 = 4, W16 = 1, WN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          cpu_req = 1'b0, cpu_we = 1'b0, sel_valid = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [15:0]   cpu_wdata = '0, cpu_keep = '0;
  logic [1:0]    sel_slot = '0;
  logic          cpu_ready, nar_stb, nar_we, wide_stb, wide_we;
  logic [15:0]   cpu_rdata, wide_wdata, wide_rdata;
  logic [AW:0]   nar_addr;
  logic [7:0]    nar_wdata, nar_rdata;
  logic [AW-1:0] wide_addr;

  logic [7:0]  bmem [0:(2**(AW+1))-1];
  logic [15:0] wmem [0:(2**AW)-1];
  assign nar_rdata  = bmem[nar_addr];
  assign wide_rdata = wmem[wide_addr];

  wbw_adapter #(.ADDR_W(AW), .NUM_SLOTS(NS), .SLOT_WIDE(SLOT_MAP),
                .WAIT8(W8), .WAIT16(W16), .WAIT_NONE(WN)) dut_i (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_keep(cpu_keep),
    .sel_valid(sel_valid), .sel_slot(sel_slot),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .nar_stb(nar_stb), .nar_we(nar_we), .nar_addr(nar_addr),
    .nar_wdata(nar_wdata), .nar_rdata(nar_rdata),
    .wide_stb(wide_stb), .wide_we(wide_we), .wide_addr(wide_addr),
    .wide_wdata(wide_wdata), .wide_rdata(wide_rdata));

  typedef struct packed { logic we; logic [15:0] addr; logic [15:0] data; } acc_t;
  typedef struct { int due; logic [15:0] data; bit chk; string tag; } exp_t;
  acc_t blog[$];
  acc_t wlog[$];
  exp_t sb[$];
  int cyc = 0, checks = 0, fails = 0;
  logic [15:0] exp_buf = '0;
  logic [15:0] last_rd = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (nar_stb) begin
      blog.push_back('{nar_we, 16'(nar_addr), 16'(nar_wdata)});
      if (nar_we) bmem[nar_addr] <= nar_wdata;
    end
    if (wide_stb) begin
      wlog.push_back('{wide_we, 16'(wide_addr), wide_wdata});
      if (wide_we) wmem[wide_addr] <= wide_wdata;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each ready pulse
  always @(negedge clk) begin
    if (!rst && cpu_ready) begin
      if (sb.size() == 0) check(0, "R9", "unexpected ready", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(cyc == e.due, "R7", "ready cycle", cyc, e.due);
        if (e.chk) check(cpu_rdata == e.data, e.tag, "read data", cpu_rdata, e.data);
        else check(cpu_rdata == last_rd, "R11", "rdata held on write", cpu_rdata, last_rd);
        if (e.chk) last_rd = cpu_rdata;
      end
    end
  end

  task automatic issue(bit wr, int a, logic [15:0] d, logic [15:0] m,
                       bit act, int slot, bit poke, string tag);
    int w, pa;
    bit wide;
    logic [15:0] exp_d, merged, saved;
    exp_t e;
    wide   = SLOT_MAP[slot];
    w      = !act ? WN : (wide ? W16 : W8);
    merged = (exp_buf & m) | (d & ~m);
    exp_d  = '0;
    if (!wr && act) exp_d = wide ? wmem[a] : {bmem[2*a], bmem[2*a+1]};
    pa     = (a + 1) % (2**AW);
    saved  = {bmem[2*pa], bmem[2*pa+1]};
    @(negedge clk);
    blog.delete(); wlog.delete();
    e.due = cyc + 1 + w; e.data = exp_d; e.chk = !wr; e.tag = tag;
    sb.push_back(e);
    cpu_req = 1'b1; cpu_we = wr; cpu_addr = AW'(a); cpu_wdata = d;
    cpu_keep = m; sel_valid = act; sel_slot = 2'(slot);
    @(negedge clk);
    cpu_req = poke;
    if (poke) begin
      cpu_we = 1'b1; cpu_addr = AW'(pa); cpu_wdata = 16'hFFFF; cpu_keep = '0;
    end
    @(negedge clk);
    cpu_req = 1'b0;
    repeat (w) @(negedge clk);
    check(sb.size() == 0, "R7", "completion seen", sb.size(), 0);
    if (!wr) exp_buf = exp_d;
    if (!act) begin
      check(blog.size() == 0 && wlog.size() == 0, "R8", "no card strobes",
            blog.size() + wlog.size(), 0);
    end else if (wide) begin
      check(wlog.size() == 1 && blog.size() == 0, "R6", "wide access count",
            wlog.size(), 1);
      if (wlog.size() == 1) begin
        check(wlog[0].addr == 16'(a) && wlog[0].we == wr, "R6", "wide addr",
              wlog[0].addr, a);
        if (wr) check(wlog[0].data == merged, tag, "wide write word",
                      wlog[0].data, merged);
      end
    end else begin
      check(blog.size() == 2 && wlog.size() == 0, "R1", "byte access count",
            blog.size(), 2);
      if (blog.size() == 2) begin
        check(blog[0].addr == 16'(2*a+1) && blog[1].addr == 16'(2*a), "R1",
              "odd then even", {blog[0].addr[7:0], blog[1].addr[7:0]},
              {8'(2*a+1), 8'(2*a)});
        if (wr) check(blog[0].data == 16'(merged[7:0]) &&
                      blog[1].data == 16'(merged[15:8]), "R5", "byte write data",
                      {blog[0].data[7:0], blog[1].data[7:0]},
                      {merged[7:0], merged[15:8]});
      end
      if (poke) check({bmem[2*pa], bmem[2*pa+1]} == saved, "R9",
                      "busy request ignored", {bmem[2*pa], bmem[2*pa+1]}, saved);
    end
  endtask

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(0, "WATCHDOG", "timeout", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2**(AW+1); i++) bmem[i] = 8'(i*7 + 3);
    for (int i = 0; i < 2**AW; i++) wmem[i] = 16'(i*16'h0101) ^ 16'h5A00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!cpu_ready && !nar_stb && !wide_stb, "R10", "reset outputs",
          {cpu_ready, nar_stb, wide_stb}, 0);
    // R10/R4: buffer is zero after reset, keep upper byte
    issue(1, 5, 16'h1234, 16'hFF00, 1, 1, 0, "R10");
    // R1 R2 R3: narrow read
    issue(0, 3, '0, '0, 1, 0, 0, "R2");
    // R4 R5: narrow partial write merged with last read
    issue(1, 9, 16'hABCD, 16'h00FF, 1, 2, 0, "R4");
    issue(0, 9, '0, '0, 1, 2, 0, "R5");
    // R6: wide read then full write
    issue(0, 7, '0, '0, 1, 3, 0, "R6");
    issue(1, 8, 16'h5A3C, 16'h0000, 1, 1, 0, "R6");
    issue(0, 8, '0, '0, 1, 1, 0, "R6");
    // R8 R3: no-card read returns zero and clears buffer
    issue(0, 2, '0, '0, 0, 0, 0, "R8");
    issue(1, 4, 16'hC3A5, 16'h0F0F, 1, 3, 0, "R3");
    issue(1, 4, 16'h7777, 16'h0000, 0, 2, 0, "R8");
    // R9: request during narrow sequence
    issue(0, 12, '0, '0, 1, 0, 1, "R9");
    issue(1, 12, 16'h8001, 16'hF0F0, 1, 0, 1, "R4");
    // back-to-back wide reads
    for (int k = 20; k < 24; k++) issue(0, k, '0, '0, 1, 1, 0, "R6");
    issue(0, 12, '0, '0, 1, 2, 0, "R2");
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule